// File: doc/BRIEF.md
# Register Cache Stage for a Counterflow Pipeline

This stage sits in a counterflow pipeline just above the instruction decoder. Instructions travel upward through it. Result bindings travel downward through it. The stage keeps one cache entry for each architectural register, and each entry holds a data word and a valid bit. A downward value result writes its register's entry and marks it valid. An upward instruction that will write a register clears that register's entry as it passes. A downward trap or mispredicted-branch binding clears every entry at once, in a single cycle. There is no attempt to track which entries the trap or misprediction affected.

When an instruction is accepted, each source binding it needs is filled from the cache if it can be. A value result arriving in the same cycle for the same register takes precedence over the stored entry. Any needed source that can be filled neither way is requested from the register file. Requests go out one register name per cycle on a valid/ready pair. The instruction is held at the stage's input until every such request has been accepted.

Both streams leave the stage through output registers, one cycle after they enter. The downward binding is copied unchanged. The upward instruction leaves with its filled source bindings.

Top module: `regcache_stage`

## Requirements
- R1: After reset, every cache entry is invalid and both output valids are low. A needed source read straight after reset therefore misses and is requested.
- R2: A downward binding with `dn_in_valid` high and kind 0 (value result) writes its data into the entry named by `dn_in_reg` and marks that entry valid. The entry can fill sources from the next cycle on.
- R3: Each source slot has a use flag. When the use flag is 1, the binding's own valid bit is 0 and the cache entry is valid, the source leaves the stage valid with the cache data. A source whose binding is already valid leaves the stage with its own data, unchanged, and is never requested.
- R4: When a value result for register X passes in the same cycle that an instruction reading X is accepted, the source is filled with the result's data, whatever the entry holds.
- R5: An accepted instruction with `up_in_dst_wr` set clears the entry of `up_in_dst_reg` at the clock edge. Its own sources are filled from the entry as it stood before that edge.
- R6: A downward binding of kind 1 (trap) or kind 2 (mispredicted branch) clears all entries in that cycle.
- R7: `req_valid` is high only while an instruction is presented and at least one of its used, unbound sources is neither in the cache nor bypassed, and has not yet been requested. Of those sources, the lowest slot index is named on `req_reg` first.
- R8: `up_in_ready` stays low while any such source has not had its request accepted. This includes a request being accepted in the current cycle while another is still waiting.
- R9: If a value result writes register X in the same cycle that an accepted instruction clears X, then X ends invalid.
- R10: `up_out_*` presents an accepted instruction one cycle after acceptance. `dn_out_*` copies `dn_in_*` one cycle later, kind included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_in_valid | input | 1 | Instruction presented from below |
| up_in_ready | output | 1 | Instruction accepted this cycle |
| up_in_dst_wr | input | 1 | Instruction writes a register |
| up_in_dst_reg | input | RW | Destination register name |
| up_in_src_use | input | NSRC | Source slot in use |
| up_in_src_reg | input | NSRC*RW | Source register names, slot 0 in the low bits |
| up_in_src_vld | input | NSRC | Source binding already valid |
| up_in_src_data | input | NSRC*DW | Source binding data |
| up_out_valid | output | 1 | Instruction leaving upward |
| up_out_dst_wr | output | 1 | Registered destination-write flag |
| up_out_dst_reg | output | RW | Registered destination name |
| up_out_src_use | output | NSRC | Registered use flags |
| up_out_src_reg | output | NSRC*RW | Registered source names |
| up_out_src_vld | output | NSRC | Source valid after filling |
| up_out_src_data | output | NSRC*DW | Source data after filling |
| dn_in_valid | input | 1 | Binding arriving from above |
| dn_in_kind | input | 2 | 0 value, 1 trap, 2 mispredicted branch, 3 no cache effect |
| dn_in_reg | input | RW | Register name of the binding |
| dn_in_data | input | DW | Value of the binding |
| dn_out_valid | output | 1 | Binding leaving downward |
| dn_out_kind | output | 2 | Registered kind |
| dn_out_reg | output | RW | Registered register name |
| dn_out_data | output | DW | Registered value |
| req_valid | output | 1 | Operand request to register file |
| req_ready | input | 1 | Request accepted |
| req_reg | output | RW | Register being requested |

## Verification
Two kinds of collision are provoked directly. The first drives a value result for a register and, in the same cycle, accepts an instruction that writes that register. The register is then read by a later instruction, which must miss and raise a request for it. The second presents a result in the same cycle as an instruction that reads the same register. The output source must carry the in-flight value, even when the stored entry is older or invalid. Flushes are judged by reading back entries that were valid before the trap or misprediction and expecting requests for all of them.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

  typedef enum logic [1:0] {
    RK_VALUE   = 2'd0,
    RK_TRAP    = 2'd1,
    RK_MISPRED = 2'd2,
    RK_OTHER   = 2'd3
  } res_kind_e;

endpackage

// File: rtl/rcs_store.sv
// Per-register cache: data words in an array with no reset (RAM-friendly),
// valid bits in flops so a flush can clear them all in one cycle.
module rcs_store #(
  parameter int NREG = 32,
  parameter int DW   = 32,
  parameter int NRD  = 2,
  localparam int RW  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [RW-1:0]     wr_reg,
  input  logic [DW-1:0]     wr_data,
  input  logic              inv_en,
  input  logic [RW-1:0]     inv_reg,
  input  logic [NRD*RW-1:0] rd_reg,
  output logic [NRD-1:0]    rd_vld,
  output logic [NRD*DW-1:0] rd_data,
  output logic [NREG-1:0]   vld_vec
);

  logic [DW-1:0]   mem [NREG];
  logic [NREG-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_reg] <= wr_data;
  end

  // Invalidation is applied after the write so it wins on a shared index.
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      vld_q <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (wr_en && (wr_reg == RW'(i)))   vld_q[i] <= 1'b1;
        if (inv_en && (inv_reg == RW'(i))) vld_q[i] <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_vld[g]            = vld_q[rd_reg[g*RW +: RW]];
    assign rd_data[g*DW +: DW]  = mem[rd_reg[g*RW +: RW]];
  end

  assign vld_vec = vld_q;

endmodule

// File: rtl/rcs_lookup.sv
// Fill logic for one source slot: own binding, then in-flight result, then cache.
module rcs_lookup #(
  parameter int DW = 32,
  parameter int RW = 5
) (
  input  logic          use_i,
  input  logic [RW-1:0] src_reg,
  input  logic          bnd_vld,
  input  logic [DW-1:0] bnd_data,
  input  logic          cache_vld,
  input  logic [DW-1:0] cache_data,
  input  logic          byp_en,
  input  logic [RW-1:0] byp_reg,
  input  logic [DW-1:0] byp_data,
  output logic          fill_vld,
  output logic [DW-1:0] fill_data,
  output logic          need
);

  logic byp_hit;

  assign byp_hit = byp_en && (byp_reg == src_reg);

  always_comb begin
    fill_vld  = bnd_vld;
    fill_data = bnd_data;
    if (use_i && !bnd_vld) begin
      if (byp_hit) begin
        fill_vld  = 1'b1;
        fill_data = byp_data;
      end else if (cache_vld) begin
        fill_vld  = 1'b1;
        fill_data = cache_data;
      end
    end
  end

  assign need = use_i && !bnd_vld && !byp_hit && !cache_vld;

endmodule

// File: rtl/rcs_reqseq.sv
// Issues one operand request per cycle, lowest slot first, and holds the
// instruction until every missing source has been handed over.
module rcs_reqseq #(
  parameter int NSRC = 2,
  parameter int RW   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ins_valid,
  input  logic [NSRC-1:0]    need,
  input  logic [NSRC*RW-1:0] src_reg,
  input  logic               req_ready,
  output logic               req_valid,
  output logic [RW-1:0]      req_reg,
  output logic               ins_ready
);

  logic [NSRC-1:0] sent_q;
  logic [NSRC-1:0] pending;
  logic [NSRC-1:0] pick;
  logic [NSRC-1:0] grant;

  assign pending = ins_valid ? (need & ~sent_q) : '0;

  always_comb begin
    pick    = '0;
    req_reg = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pending[i]) begin
        pick    = '0;
        pick[i] = 1'b1;
        req_reg = src_reg[i*RW +: RW];
      end
    end
  end

  assign req_valid = |pending;
  assign grant     = (req_valid && req_ready) ? pick : '0;
  assign ins_ready = ((pending & ~grant) == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sent_q <= '0;
    end else if (ins_valid && ins_ready) begin
      sent_q <= '0;
    end else begin
      sent_q <= sent_q | grant;
    end
  end

endmodule

// File: rtl/regcache_stage.sv
module regcache_stage
  import rcs_pkg::*;
#(
  parameter int NREG = 32,
  parameter int DW   = 32,
  parameter int NSRC = 2,
  localparam int RW  = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               up_in_valid,
  output logic               up_in_ready,
  input  logic               up_in_dst_wr,
  input  logic [RW-1:0]      up_in_dst_reg,
  input  logic [NSRC-1:0]    up_in_src_use,
  input  logic [NSRC*RW-1:0] up_in_src_reg,
  input  logic [NSRC-1:0]    up_in_src_vld,
  input  logic [NSRC*DW-1:0] up_in_src_data,
  output logic               up_out_valid,
  output logic               up_out_dst_wr,
  output logic [RW-1:0]      up_out_dst_reg,
  output logic [NSRC-1:0]    up_out_src_use,
  output logic [NSRC*RW-1:0] up_out_src_reg,
  output logic [NSRC-1:0]    up_out_src_vld,
  output logic [NSRC*DW-1:0] up_out_src_data,
  input  logic               dn_in_valid,
  input  logic [1:0]         dn_in_kind,
  input  logic [RW-1:0]      dn_in_reg,
  input  logic [DW-1:0]      dn_in_data,
  output logic               dn_out_valid,
  output logic [1:0]         dn_out_kind,
  output logic [RW-1:0]      dn_out_reg,
  output logic [DW-1:0]      dn_out_data,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [RW-1:0]      req_reg
);

  logic               res_wr;
  logic               res_flush;
  logic               ins_fire;
  logic [NSRC-1:0]    c_vld;
  logic [NSRC*DW-1:0] c_data;
  logic [NSRC-1:0]    f_vld;
  logic [NSRC*DW-1:0] f_data;
  logic [NSRC-1:0]    need;
  logic [NREG-1:0]    cache_vld;

  assign res_wr    = dn_in_valid && (dn_in_kind == RK_VALUE);
  assign res_flush = dn_in_valid && ((dn_in_kind == RK_TRAP) || (dn_in_kind == RK_MISPRED));
  assign ins_fire  = up_in_valid && up_in_ready;

  rcs_store #(.NREG(NREG), .DW(DW), .NRD(NSRC)) u_store (
    .clk     (clk),
    .rst     (rst),
    .flush   (res_flush),
    .wr_en   (res_wr),
    .wr_reg  (dn_in_reg),
    .wr_data (dn_in_data),
    .inv_en  (ins_fire && up_in_dst_wr),
    .inv_reg (up_in_dst_reg),
    .rd_reg  (up_in_src_reg),
    .rd_vld  (c_vld),
    .rd_data (c_data),
    .vld_vec (cache_vld)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    rcs_lookup #(.DW(DW), .RW(RW)) u_lookup (
      .use_i      (up_in_src_use[g]),
      .src_reg    (up_in_src_reg[g*RW +: RW]),
      .bnd_vld    (up_in_src_vld[g]),
      .bnd_data   (up_in_src_data[g*DW +: DW]),
      .cache_vld  (c_vld[g]),
      .cache_data (c_data[g*DW +: DW]),
      .byp_en     (res_wr),
      .byp_reg    (dn_in_reg),
      .byp_data   (dn_in_data),
      .fill_vld   (f_vld[g]),
      .fill_data  (f_data[g*DW +: DW]),
      .need       (need[g])
    );
  end

  rcs_reqseq #(.NSRC(NSRC), .RW(RW)) u_req (
    .clk       (clk),
    .rst       (rst),
    .ins_valid (up_in_valid),
    .need      (need),
    .src_reg   (up_in_src_reg),
    .req_ready (req_ready),
    .req_valid (req_valid),
    .req_reg   (req_reg),
    .ins_ready (up_in_ready)
  );

  // Output registers: valids reset, payload loads only with its valid.
  always_ff @(posedge clk) begin
    if (rst) begin
      up_out_valid <= 1'b0;
      dn_out_valid <= 1'b0;
    end else begin
      up_out_valid <= ins_fire;
      dn_out_valid <= dn_in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (ins_fire) begin
      up_out_dst_wr   <= up_in_dst_wr;
      up_out_dst_reg  <= up_in_dst_reg;
      up_out_src_use  <= up_in_src_use;
      up_out_src_reg  <= up_in_src_reg;
      up_out_src_vld  <= f_vld;
      up_out_src_data <= f_data;
    end
    if (dn_in_valid) begin
      dn_out_kind <= dn_in_kind;
      dn_out_reg  <= dn_in_reg;
      dn_out_data <= dn_in_data;
    end
  end

endmodule

// File: rtl/rcs_checker.sv
module rcs_checker #(
  parameter int NREG = 32,
  parameter int RW   = 5
) (
  input logic            clk,
  input logic            rst,
  input logic [NREG-1:0] vld_vec,
  input logic            up_in_valid,
  input logic            up_in_ready,
  input logic            up_in_dst_wr,
  input logic [RW-1:0]   up_in_dst_reg,
  input logic            up_out_valid,
  input logic            dn_in_valid,
  input logic [1:0]      dn_in_kind,
  input logic [RW-1:0]   dn_in_reg,
  input logic            req_valid,
  input logic            req_ready
);

  a_r1_empty_after_reset: assert property (@(posedge clk)
    rst |=> (vld_vec == '0));

  a_r2_result_sets_entry: assert property (@(posedge clk) disable iff (rst)
    (dn_in_valid && dn_in_kind == 2'd0 &&
     !(up_in_valid && up_in_ready && up_in_dst_wr && up_in_dst_reg == dn_in_reg))
    |=> vld_vec[$past(dn_in_reg)]);

  a_r6_flush_clears_all: assert property (@(posedge clk) disable iff (rst)
    (dn_in_valid && (dn_in_kind == 2'd1 || dn_in_kind == 2'd2)) |=> (vld_vec == '0));

  a_r9_invalidate_wins: assert property (@(posedge clk) disable iff (rst)
    (up_in_valid && up_in_ready && up_in_dst_wr && dn_in_valid &&
     dn_in_kind == 2'd0 && dn_in_reg == up_in_dst_reg)
    |=> !vld_vec[$past(up_in_dst_reg)]);

  a_r7_request_has_instr: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> up_in_valid);

  a_r8_stall_when_refused: assert property (@(posedge clk) disable iff (rst)
    (up_in_valid && req_valid && !req_ready) |-> !up_in_ready);

  a_r10_out_follows_accept: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (up_out_valid == $past(up_in_valid && up_in_ready)));

endmodule

bind regcache_stage rcs_checker #(.NREG(NREG), .RW(RW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .vld_vec       (cache_vld),
  .up_in_valid   (up_in_valid),
  .up_in_ready   (up_in_ready),
  .up_in_dst_wr  (up_in_dst_wr),
  .up_in_dst_reg (up_in_dst_reg),
  .up_out_valid  (up_out_valid),
  .dn_in_valid   (dn_in_valid),
  .dn_in_kind    (dn_in_kind),
  .dn_in_reg     (dn_in_reg),
  .req_valid     (req_valid),
  .req_ready     (req_ready)
);

// File: tb/regcache_stage_tb.sv
module regcache_stage_tb;

  localparam int CLK_PERIOD = 10;
  localparam int RW = 5;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst;
  logic up_in_valid, up_in_ready, up_in_dst_wr;
  logic [RW-1:0] up_in_dst_reg;
  logic [1:0] up_in_src_use, up_in_src_vld;
  logic [2*RW-1:0] up_in_src_reg;
  logic [2*DW-1:0] up_in_src_data;
  logic up_out_valid, up_out_dst_wr;
  logic [RW-1:0] up_out_dst_reg;
  logic [1:0] up_out_src_use, up_out_src_vld;
  logic [2*RW-1:0] up_out_src_reg;
  logic [2*DW-1:0] up_out_src_data;
  logic dn_in_valid, dn_out_valid;
  logic [1:0] dn_in_kind, dn_out_kind;
  logic [RW-1:0] dn_in_reg, dn_out_reg;
  logic [DW-1:0] dn_in_data, dn_out_data;
  logic req_valid, req_ready;
  logic [RW-1:0] req_reg;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regcache_stage u_dut (
    .clk(clk), .rst(rst),
    .up_in_valid(up_in_valid), .up_in_ready(up_in_ready),
    .up_in_dst_wr(up_in_dst_wr), .up_in_dst_reg(up_in_dst_reg),
    .up_in_src_use(up_in_src_use), .up_in_src_reg(up_in_src_reg),
    .up_in_src_vld(up_in_src_vld), .up_in_src_data(up_in_src_data),
    .up_out_valid(up_out_valid), .up_out_dst_wr(up_out_dst_wr),
    .up_out_dst_reg(up_out_dst_reg), .up_out_src_use(up_out_src_use),
    .up_out_src_reg(up_out_src_reg), .up_out_src_vld(up_out_src_vld),
    .up_out_src_data(up_out_src_data),
    .dn_in_valid(dn_in_valid), .dn_in_kind(dn_in_kind),
    .dn_in_reg(dn_in_reg), .dn_in_data(dn_in_data),
    .dn_out_valid(dn_out_valid), .dn_out_kind(dn_out_kind),
    .dn_out_reg(dn_out_reg), .dn_out_data(dn_out_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_reg(req_reg)
  );

  typedef struct packed {
    logic          rv;  logic [4:0] rr; logic [31:0] rd;
    logic          iv;  logic dw; logic [4:0] dr;
    logic          u0;  logic [4:0] s0; logic u1; logic [4:0] s1;
    logic          e0v; logic [31:0] e0d; logic e1v; logic [31:0] e1d;
  } row_t;

  localparam row_t TBL [8] = '{
    '{1'b1, 5'd3, 32'hA3, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 32'h0,  1'b0, 32'h0},
    '{1'b1, 5'd5, 32'hB5, 1'b1, 1'b0, 5'd0, 1'b1, 5'd3, 1'b0, 5'd0, 1'b1, 32'hA3, 1'b0, 32'h0},
    '{1'b0, 5'd0, 32'h0,  1'b1, 1'b0, 5'd0, 1'b1, 5'd5, 1'b1, 5'd3, 1'b1, 32'hB5, 1'b1, 32'hA3},
    '{1'b1, 5'd7, 32'hC7, 1'b1, 1'b0, 5'd0, 1'b1, 5'd7, 1'b1, 5'd5, 1'b1, 32'hC7, 1'b1, 32'hB5},
    '{1'b0, 5'd0, 32'h0,  1'b1, 1'b1, 5'd5, 1'b1, 5'd5, 1'b0, 5'd0, 1'b1, 32'hB5, 1'b0, 32'h0},
    '{1'b1, 5'd9, 32'hD9, 1'b1, 1'b0, 5'd0, 1'b1, 5'd5, 1'b0, 5'd0, 1'b0, 32'h0,  1'b0, 32'h0},
    '{1'b1, 5'd3, 32'hE3, 1'b1, 1'b0, 5'd0, 1'b1, 5'd3, 1'b1, 5'd9, 1'b1, 32'hE3, 1'b1, 32'hD9},
    '{1'b0, 5'd0, 32'h0,  1'b1, 1'b0, 5'd0, 1'b1, 5'd3, 1'b1, 5'd7, 1'b1, 32'hE3, 1'b1, 32'hC7}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    up_in_valid = 0; up_in_dst_wr = 0; up_in_dst_reg = '0;
    up_in_src_use = '0; up_in_src_reg = '0; up_in_src_vld = '0; up_in_src_data = '0;
    dn_in_valid = 0; dn_in_kind = 2'd0; dn_in_reg = '0; dn_in_data = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic result(input logic [1:0] k, input logic [4:0] r, input logic [31:0] d);
    dn_in_valid = 1; dn_in_kind = k; dn_in_reg = r; dn_in_data = d;
  endtask

  task automatic instr(input logic u0, input logic [4:0] s0, input logic u1, input logic [4:0] s1);
    up_in_valid = 1; up_in_src_use = {u1, u0}; up_in_src_reg = {s1, s0};
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle();
    req_ready = 1'b0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    tick();

    // R1: reset state
    chk("R1 up_out_valid", up_out_valid, 0);
    chk("R1 dn_out_valid", dn_out_valid, 0);
    chk("R1 req idle", req_valid, 0);
    instr(1, 5'd1, 0, 5'd0);
    #1;
    chk("R1 empty entry requested", req_valid, 1);
    chk("R1 req_reg", req_reg, 1);
    idle();
    tick();

    // Table walk: R2 R3 R4 R5 R7 R10
    req_ready = 1'b1;
    for (int i = 0; i < 8; i++) begin
      idle();
      if (TBL[i].rv) result(2'd0, TBL[i].rr, TBL[i].rd);
      if (TBL[i].iv) begin
        instr(TBL[i].u0, TBL[i].s0, TBL[i].u1, TBL[i].s1);
        up_in_dst_wr = TBL[i].dw; up_in_dst_reg = TBL[i].dr;
      end
      tick();
      chk($sformatf("R10 row %0d up_out_valid", i), up_out_valid, TBL[i].iv);
      chk($sformatf("R10 row %0d dn_out_valid", i), dn_out_valid, TBL[i].rv);
      if (TBL[i].rv) chk($sformatf("R10 row %0d dn_out_data", i), dn_out_data, TBL[i].rd);
      if (TBL[i].iv) begin
        chk($sformatf("R3 R4 R5 R7 row %0d src0 valid", i), up_out_src_vld[0], TBL[i].e0v);
        if (TBL[i].e0v) chk($sformatf("R2 R3 R4 row %0d src0 data", i), up_out_src_data[31:0], TBL[i].e0d);
        chk($sformatf("R3 R4 row %0d src1 valid", i), up_out_src_vld[1], TBL[i].e1v);
        if (TBL[i].e1v) chk($sformatf("R2 R3 R4 row %0d src1 data", i), up_out_src_data[63:32], TBL[i].e1d);
      end
    end
    idle();

    // R3: bound source passes unchanged, no request
    instr(1, 5'd3, 0, 5'd0);
    up_in_src_vld = 2'b01; up_in_src_data[31:0] = 32'h55AA;
    #1;
    chk("R3 bound source not requested", req_valid, 0);
    tick();
    chk("R3 bound data kept", up_out_src_data[31:0], 32'h55AA);
    idle();

    // R9: write and invalidation of r10 in one cycle
    result(2'd0, 5'd10, 32'h1010);
    up_in_valid = 1; up_in_dst_wr = 1; up_in_dst_reg = 5'd10;
    tick();
    idle();
    instr(1, 5'd10, 0, 5'd0);
    #1;
    chk("R9 r10 misses", req_valid, 1);
    chk("R9 req_reg", req_reg, 10);
    tick();
    chk("R9 src invalid", up_out_src_vld[0], 0);
    idle();

    // R6: trap flush
    result(2'd0, 5'd11, 32'h11); tick();
    result(2'd0, 5'd12, 32'h12); tick();
    result(2'd1, 5'd0, 32'h0); tick();
    chk("R10 trap kind passed", dn_out_kind, 1);
    idle();
    req_ready = 1'b0;
    instr(1, 5'd11, 1, 5'd12);
    #1;
    chk("R6 trap cleared r11", req_reg, 11);
    chk("R8 stall on refused", up_in_ready, 0);
    idle();
    tick();

    // R6: misprediction flush
    result(2'd0, 5'd13, 32'h13); tick();
    result(2'd2, 5'd0, 32'h0); tick();
    idle();
    instr(1, 5'd13, 0, 5'd0);
    #1;
    chk("R6 mispredict cleared r13", req_valid, 1);
    idle();
    tick();

    // R7 R8: two misses, one request at a time
    instr(1, 5'd20, 1, 5'd21);
    #1;
    chk("R7 first request lowest slot", req_reg, 20);
    chk("R8 held while refused", up_in_ready, 0);
    tick();
    req_ready = 1'b1;
    #1;
    chk("R8 held with second pending", up_in_ready, 0);
    tick();
    #1;
    chk("R7 second request", req_reg, 21);
    chk("R8 released", up_in_ready, 1);
    tick();
    chk("R10 accepted after requests", up_out_valid, 1);
    idle();
    tick();
    chk("R10 single output", up_out_valid, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule